// File: doc/BRIEF.md
# Elastic-Buffer Fill Servo

This block keeps an elastic buffer between two clock domains close to half full. It does this by trimming the clock rate on one side of the buffer. On each update tick it takes the writer and reader positions and forms the fill level as their modular distance. It subtracts that level from a setpoint of half the buffer depth. The difference goes through a proportional-only or a proportional-integral law, and the result leaves the block as a signed, clamped trim word for an oscillator or NCO.

The buffer acts as an integrating plant: a rate mismatch makes the fill level ramp. In proportional-only mode the loop settles with a constant residual offset from half full. In PI mode the accumulated error supplies the trim that the mismatch needs, so the fill level settles at exactly half. Both gains are power-of-two shifts. The integrator saturates at a programmable bound so that it cannot wind up.

A three-state sequencer runs each update. **S_IDLE** waits for a tick; the transition *accept* captures the error and moves to **S_ACCUM**. The transition *accumulate* updates the integrator and moves to **S_APPLY**. The transition *publish* loads the trim word, raises the update strobe and returns to **S_IDLE**. In any other case each state stays where it is (S_IDLE without a tick).

Top module: `fill_servo`

## Requirements
- R1: After reset, `trim` is 0 and `trim_upd` is 0 until the first update completes; the integrator starts at zero.
- R2: The fill level is `(wr_pos - rd_pos) mod 2^(PTR_W+1)` and the error is `2^(PTR_W-1) - fill`, with positions counted with one wrap bit above a depth of 2^PTR_W.
- R3: A tick seen in S_IDLE at clock edge k updates `trim` at edge k+2. `trim_upd` is high for exactly the one cycle after that edge, and `trim` holds its value at all other times.
- R4: Ticks at edges k+1 and k+2, while an update is in progress, are ignored.
- R5: With `pi_mode`=0, trim = clamp(err * 2^kp_shift) and the integrator is forced to zero.
- R6: With `pi_mode`=1, the integrator becomes sat(integ + err) and trim = clamp(err * 2^kp_shift + floor(integ / 2^ki_shift)), using the updated integrator.
- R7: The trim word is clamped to the range [-trim_limit, +trim_limit].
- R8: The integrator saturates to the range [-int_limit, +int_limit].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Update request strobe |
| pi_mode | input | 1 | 1 = proportional-integral, 0 = proportional only |
| kp_shift | input | SHIFT_W | Proportional gain as a left shift |
| ki_shift | input | SHIFT_W | Integral gain as a right shift |
| trim_limit | input | TRIM_W-1 | Magnitude bound for the trim word |
| int_limit | input | INT_W-1 | Magnitude bound for the integrator |
| wr_pos | input | PTR_W+1 | Writer position, with wrap bit |
| rd_pos | input | PTR_W+1 | Reader position, with wrap bit |
| trim | output | TRIM_W | Signed frequency trim |
| trim_upd | output | 1 | One-cycle strobe when `trim` changes |

## Verification
Positions are driven below, at and above the setpoint, and across the wrap of the pointer counter. These cases separate a correct modular distance from a plain subtraction. Proportional runs sweep the shift, and large shifts push the result into both clamp rails. A PI run ramps the integrator into saturation, then applies zero and negative errors. That shows a nonzero trim at zero error and floor rounding of negative integrator values. It also shows that returning to proportional mode clears the accumulated term. A tick held for several cycles tells whether busy-time ticks are dropped or start extra updates.

// File: rtl/fill_servo_pkg.sv
package fill_servo_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ACCUM = 2'd1,
        S_APPLY = 2'd2
    } servo_state_e;
endpackage

// File: rtl/fill_meter.sv
module fill_meter #(
    parameter int PTR_W = 6,
    parameter int ERR_W = PTR_W + 2
) (
    input  logic [PTR_W:0]           wr_pos,
    input  logic [PTR_W:0]           rd_pos,
    output logic signed [ERR_W-1:0]  err
);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [ERR_W-1:0] HALF = ERR_W'(1) << (PTR_W - 1);

    logic [CNT_W-1:0] fill;

    // modular distance between writer and reader, wrap bit included
    assign fill = wr_pos - rd_pos;
    assign err  = $signed(HALF - {1'b0, fill});
endmodule

// File: rtl/servo_integ.sv
module servo_integ #(
    parameter int ERR_W = 8,
    parameter int INT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     clr,
    input  logic signed [ERR_W-1:0]  err,
    input  logic [INT_W-2:0]         lim,
    output logic signed [INT_W-1:0]  q
);
    localparam int EXT_W = INT_W + 1;

    logic signed [EXT_W-1:0] sum;
    logic signed [EXT_W-1:0] lim_p;
    logic signed [EXT_W-1:0] lim_n;
    logic signed [INT_W-1:0] nxt;

    assign lim_p = $signed({2'b00, lim});
    assign lim_n = -lim_p;
    assign sum   = $signed({q[INT_W-1], q}) +
                   $signed({{(EXT_W-ERR_W){err[ERR_W-1]}}, err});

    always_comb begin
        if (sum > lim_p)      nxt = lim_p[INT_W-1:0];
        else if (sum < lim_n) nxt = lim_n[INT_W-1:0];
        else                  nxt = sum[INT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (en)  q <= clr ? '0 : nxt;
    end

    AST_INTEG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ($signed({q[INT_W-1], q}) <= $past(lim_p) &&
                $signed({q[INT_W-1], q}) >= $past(lim_n))); // R8
    AST_PMODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr) |=> (q == '0)); // R5
endmodule

// File: rtl/trim_shaper.sv
module trim_shaper #(
    parameter int ERR_W   = 8,
    parameter int INT_W   = 16,
    parameter int TRIM_W  = 12,
    parameter int SHIFT_W = 3
) (
    input  logic signed [ERR_W-1:0]  err,
    input  logic signed [INT_W-1:0]  integ,
    input  logic [SHIFT_W-1:0]       kp_shift,
    input  logic [SHIFT_W-1:0]       ki_shift,
    input  logic [TRIM_W-2:0]        lim,
    output logic signed [TRIM_W-1:0] trim_nxt
);
    localparam int P_W   = ERR_W + (1 << SHIFT_W);
    localparam int SUM_W = ((P_W > INT_W) ? P_W : INT_W) + 1;

    logic signed [SUM_W-1:0] err_ext;
    logic signed [SUM_W-1:0] int_ext;
    logic signed [SUM_W-1:0] p_term;
    logic signed [SUM_W-1:0] i_term;
    logic signed [SUM_W-1:0] total;
    logic signed [SUM_W-1:0] lim_p;
    logic signed [SUM_W-1:0] lim_n;

    assign err_ext = $signed({{(SUM_W-ERR_W){err[ERR_W-1]}}, err});
    assign int_ext = $signed({{(SUM_W-INT_W){integ[INT_W-1]}}, integ});
    assign p_term  = err_ext <<< kp_shift;
    assign i_term  = int_ext >>> ki_shift;
    assign total   = p_term + i_term;
    assign lim_p   = $signed({{(SUM_W-TRIM_W+1){1'b0}}, lim});
    assign lim_n   = -lim_p;

    always_comb begin
        if (total > lim_p)      trim_nxt = lim_p[TRIM_W-1:0];
        else if (total < lim_n) trim_nxt = lim_n[TRIM_W-1:0];
        else                    trim_nxt = total[TRIM_W-1:0];
    end
endmodule

// File: rtl/fill_servo.sv
module fill_servo
    import fill_servo_pkg::*;
#(
    parameter int PTR_W   = 6,
    parameter int INT_W   = 16,
    parameter int TRIM_W  = 12,
    parameter int SHIFT_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      pi_mode,
    input  logic [SHIFT_W-1:0]        kp_shift,
    input  logic [SHIFT_W-1:0]        ki_shift,
    input  logic [TRIM_W-2:0]         trim_limit,
    input  logic [INT_W-2:0]          int_limit,
    input  logic [PTR_W:0]            wr_pos,
    input  logic [PTR_W:0]            rd_pos,
    output logic signed [TRIM_W-1:0]  trim,
    output logic                      trim_upd
);
    localparam int ERR_W = PTR_W + 2;

    servo_state_e state, state_nxt;

    logic signed [ERR_W-1:0]  err_now;
    logic signed [ERR_W-1:0]  err_q;
    logic signed [INT_W-1:0]  integ;
    logic signed [TRIM_W-1:0] trim_nxt;

    fill_meter #(.PTR_W(PTR_W), .ERR_W(ERR_W)) u_meter (
        .wr_pos (wr_pos),
        .rd_pos (rd_pos),
        .err    (err_now)
    );

    servo_integ #(.ERR_W(ERR_W), .INT_W(INT_W)) u_integ (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state == S_ACCUM),
        .clr   (!pi_mode),
        .err   (err_q),
        .lim   (int_limit),
        .q     (integ)
    );

    trim_shaper #(.ERR_W(ERR_W), .INT_W(INT_W), .TRIM_W(TRIM_W),
                  .SHIFT_W(SHIFT_W)) u_shaper (
        .err      (err_q),
        .integ    (integ),
        .kp_shift (kp_shift),
        .ki_shift (ki_shift),
        .lim      (trim_limit),
        .trim_nxt (trim_nxt)
    );

    // next-state: accept -> accumulate -> publish
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (tick) state_nxt = S_ACCUM;
            S_ACCUM: state_nxt = S_APPLY;
            S_APPLY: state_nxt = S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q    <= '0;
            trim     <= '0;
            trim_upd <= 1'b0;
        end else begin
            trim_upd <= 1'b0;
            unique case (state)
                S_IDLE:  if (tick) err_q <= err_now;
                S_ACCUM: ;
                S_APPLY: begin
                    trim     <= trim_nxt;
                    trim_upd <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trim_upd |=> !trim_upd); // R3
    AST_TRIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_APPLY) |=> $stable(trim)); // R3
    AST_TRIM_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        trim_upd |-> (trim <= $signed({1'b0, $past(trim_limit)}) &&
                      trim >= -$signed({1'b0, $past(trim_limit)}))); // R7
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && tick) |=> (state != S_ACCUM)); // R4
endmodule

// File: tb/test_fill_servo.sv
module test_fill_servo;
    localparam int PTR_W = 6, INT_W = 16, TRIM_W = 12, SHIFT_W = 3;
    localparam int HALF = 32, MODV = 128;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pi_mode = 1'b0;
    logic [SHIFT_W-1:0] kp_shift = '0, ki_shift = '0;
    logic [TRIM_W-2:0] trim_limit = 11'd1000;
    logic [INT_W-2:0]  int_limit = 15'd50;
    logic [PTR_W:0] wr_pos = '0, rd_pos = '0;
    logic signed [TRIM_W-1:0] trim;
    logic trim_upd;

    fill_servo #(.PTR_W(PTR_W), .INT_W(INT_W), .TRIM_W(TRIM_W),
                 .SHIFT_W(SHIFT_W)) i_fill_servo (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pi_mode(pi_mode),
        .kp_shift(kp_shift), .ki_shift(ki_shift), .trim_limit(trim_limit),
        .int_limit(int_limit), .wr_pos(wr_pos), .rd_pos(rd_pos),
        .trim(trim), .trim_upd(trim_upd));

    always #4 clk = ~clk;   // 125 MHz

    int vectors = 0, miscompares = 0, cycles = 0, upd_seen = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural reference model
    int ph = 0, m_err = 0, m_integ = 0, m_trim = 0, m_upd = 0;
    always @(posedge clk) begin
        int f, s, lim;
        if (!rst_n) begin
            ph = 0; m_err = 0; m_integ = 0; m_trim = 0; m_upd = 0;
        end else begin
            m_upd = 0;
            case (ph)
                0: if (tick) begin
                       f = (int'(wr_pos) - int'(rd_pos) + MODV) % MODV;
                       m_err = HALF - f;
                       ph = 1;
                   end
                1: begin
                       lim = int'(int_limit);
                       if (pi_mode) begin
                           s = m_integ + m_err;
                           if (s > lim) s = lim;
                           if (s < -lim) s = -lim;
                           m_integ = s;
                       end else m_integ = 0;
                       ph = 2;
                   end
                default: begin
                       lim = int'(trim_limit);
                       s = m_err * (1 << kp_shift) + (m_integ >>> ki_shift);
                       if (s > lim) s = lim;
                       if (s < -lim) s = -lim;
                       m_trim = s; m_upd = 1; ph = 0;
                   end
            endcase
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (int'(trim) != m_trim || int'(trim_upd) != m_upd) begin
                miscompares++;
                $display("FAIL %s (R3 timing) trim=%0d upd=%0d expected trim=%0d upd=%0d",
                         cur_req, trim, trim_upd, m_trim, m_upd);
            end
            if (trim_upd) upd_seen++;
        end
    end

    task automatic expect_trim(input int exp, input string req);
        vectors++;
        if (int'(trim) != exp) begin
            miscompares++;
            $display("FAIL %s trim actual %0d expected %0d", req, trim, exp);
        end
    endtask

    task automatic do_update(input int wr, input int rd);
        @(negedge clk);
        wr_pos = (PTR_W+1)'(wr); rd_pos = (PTR_W+1)'(rd); tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        expect_trim(0, "R1");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        expect_trim(0, "R1");

        // R2 / R5: proportional mode, distance and wrap
        cur_req = "R5";
        do_update(10, 0);   expect_trim(22, "R2");
        do_update(5, 120);  expect_trim(19, "R2");
        do_update(32, 0);   expect_trim(0, "R5");
        kp_shift = 3'd2;
        do_update(10, 0);   expect_trim(88, "R5");

        // R7: clamp rails
        cur_req = "R7";
        kp_shift = 3'd7;
        do_update(10, 0);   expect_trim(1000, "R7");
        do_update(64, 0);   expect_trim(-1000, "R7");

        // R6 / R8: PI accumulation, saturation, floor rounding
        cur_req = "R6";
        pi_mode = 1'b1; kp_shift = 3'd0; ki_shift = 3'd1;
        do_update(22, 0);   expect_trim(15, "R6");
        do_update(22, 0);   expect_trim(20, "R6");
        do_update(22, 0);   expect_trim(25, "R6");
        do_update(22, 0);   expect_trim(30, "R6");
        do_update(22, 0);   expect_trim(35, "R6");
        cur_req = "R8";
        do_update(22, 0);   expect_trim(35, "R8");
        cur_req = "R6";
        do_update(32, 0);   expect_trim(25, "R6");
        do_update(52, 0);   expect_trim(-5, "R6");
        do_update(33, 0);   expect_trim(13, "R6");
        do_update(52, 0);   expect_trim(-16, "R6");
        do_update(52, 0);   expect_trim(-26, "R6");

        // R5: proportional mode clears the integrator
        cur_req = "R5";
        pi_mode = 1'b0;
        do_update(32, 0);   expect_trim(0, "R5");
        pi_mode = 1'b1;
        do_update(32, 0);   expect_trim(0, "R5");

        // R4: tick held through a busy update
        cur_req = "R4";
        pi_mode = 1'b0;
        @(negedge clk);
        upd_seen = 0;
        wr_pos = 7'd30; rd_pos = 7'd0; tick = 1'b1;
        repeat (3) @(negedge clk);
        tick = 1'b0;
        repeat (4) @(negedge clk);
        vectors++;
        if (upd_seen != 1) begin
            miscompares++;
            $display("FAIL R4 update count actual %0d expected 1", upd_seen);
        end
        expect_trim(2, "R4");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule